// File: doc/BRIEF.md
# Long-Operand Effective-Address Fetcher

This block obtains the 32-bit source operand of a long-form arithmetic instruction on a 68000-style core. The core pulses `start` with the 6-bit effective-address field of the opcode. The block then walks through a short sequence. It reads the register file through a combinational read port. It picks up any displacement, absolute address or immediate from the instruction stream. Where the mode needs it, it reads memory through a request/ready bus.

When the fetch ends, the block pulses `done` for one cycle. In that same cycle it presents three results: the operand, the number of extra instruction-stream bytes the mode used, and a flag that marks an unsupported addressing mode. These results stay as they are until a later fetch completes. The instruction stream is read as 16-bit words at byte offsets 4 and 6, because a 16-bit extension word already sits at offset 2 after the opcode.

Top module: `ea_long_fetch`

## Requirements
- R1: The mode is `ea_field[5:3]` and the register number is `ea_field[2:0]`. The register number appears on `reg_idx`. Mode 0 returns `dreg_rdata` with `extra_bytes`=0, and `done` is high in the second cycle after the `start` cycle.
- R2: Mode 1 returns `areg_rdata` with `extra_bytes`=0, and no memory request is made.
- R3: Mode 2 reads memory at the address in `areg_rdata` and returns `mem_rdata` with `extra_bytes`=0.
- R4: Mode 5 reads memory at `areg_rdata` plus the sign-extended 16-bit word taken at instruction offset 4, and reports `extra_bytes`=2.
- R5: Mode 7 with register 0 reads memory at the sign-extended 16-bit word at offset 4, and reports `extra_bytes`=2.
- R6: Mode 7 with register 1 reads memory at a 32-bit address. The upper half is the word at offset 4 and the lower half is the word at offset 6. It reports `extra_bytes`=4.
- R7: Mode 7 with register 4 returns the immediate formed from the word at offset 4 (upper half) and the word at offset 6 (lower half). It reports `extra_bytes`=4 and makes no memory request.
- R8: Every other mode and register pair sets `unsupported`=1, `operand`=0 and `extra_bytes`=0, and makes no memory request.
- R9: `mem_req` stays high, with `mem_addr` stable, until the cycle in which `mem_ready` is high. The operand is the `mem_rdata` of that cycle.
- R10: `done` is a one-cycle pulse. `operand`, `extra_bytes` and `unsupported` change only together with `done`. A `start` pulse that arrives while a fetch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fetch (accepted only when idle) |
| ea_field | input | 6 | Effective-address field: mode in bits 5:3, register in bits 2:0 |
| reg_idx | output | 3 | Register number for the register-file read |
| dreg_rdata | input | 32 | Data register selected by `reg_idx` |
| areg_rdata | input | 32 | Address register selected by `reg_idx` |
| ifetch_off | output | 3 | Instruction-stream byte offset being read (4 or 6) |
| ifetch_word | input | 16 | Instruction-stream word at `ifetch_off` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ready | input | 1 | Memory read complete |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 32 | Fetched operand |
| extra_bytes | output | 3 | Extra instruction-stream bytes used |
| unsupported | output | 1 | Mode is not supported |

## Verification
The case hardest to reach from the ports is a second `start` that lands while a memory read is stalled. The bench holds `mem_ready` low for several cycles. It pulses `start` with a register-direct field in the middle of that stall. It then checks that the first result still arrives and that no second `done` follows. The bench's memory responder also sweeps the wait-state count from zero upward. This checks the request hold and the completion cycle at every stall length.

// File: rtl/ea_long_fetch.sv
module ea_long_fetch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    ea_field,
  output logic [2:0]    reg_idx,
  input  logic [DW-1:0] dreg_rdata,
  input  logic [DW-1:0] areg_rdata,
  output logic [2:0]    ifetch_off,
  input  logic [15:0]   ifetch_word,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] operand,
  output logic [2:0]    extra_bytes,
  output logic          unsupported
);
  localparam int HW = DW - 16;

  typedef enum logic [1:0] {S_IDLE, S_DEC, S_EXT, S_MEM} state_t;

  state_t      state;
  logic [5:0]  ea_q;
  logic [15:0] hi_q;
  logic [2:0]  bytes_q;
  logic [AW-1:0] addr_q;

  wire [2:0]    mode  = ea_q[5:3];
  wire [2:0]    rnum  = ea_q[2:0];
  wire [AW-1:0] sword = {{(AW-16){ifetch_word[15]}}, ifetch_word};

  assign reg_idx    = rnum;
  assign ifetch_off = (state == S_EXT) ? 3'd6 : 3'd4;
  assign mem_req    = (state == S_MEM);
  assign mem_addr   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      ea_q        <= '0;
      hi_q        <= '0;
      bytes_q     <= '0;
      addr_q      <= '0;
      done        <= 1'b0;
      operand     <= '0;
      extra_bytes <= '0;
      unsupported <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          ea_q  <= ea_field;
          state <= S_DEC;
        end
        S_DEC: begin
          state <= S_IDLE;
          case (mode)
            3'd0: begin
              done <= 1'b1; operand <= dreg_rdata; extra_bytes <= 3'd0; unsupported <= 1'b0;
            end
            3'd1: begin
              done <= 1'b1; operand <= areg_rdata; extra_bytes <= 3'd0; unsupported <= 1'b0;
            end
            3'd2: begin
              addr_q <= areg_rdata[AW-1:0]; bytes_q <= 3'd0; state <= S_MEM;
            end
            3'd5: begin
              addr_q <= areg_rdata[AW-1:0] + sword; bytes_q <= 3'd2; state <= S_MEM;
            end
            3'd7: begin
              case (rnum)
                3'd0: begin
                  addr_q <= sword; bytes_q <= 3'd2; state <= S_MEM;
                end
                3'd1, 3'd4: begin
                  hi_q <= ifetch_word; state <= S_EXT;
                end
                default: begin
                  done <= 1'b1; operand <= '0; extra_bytes <= 3'd0; unsupported <= 1'b1;
                end
              endcase
            end
            default: begin
              done <= 1'b1; operand <= '0; extra_bytes <= 3'd0; unsupported <= 1'b1;
            end
          endcase
        end
        S_EXT: begin
          if (rnum == 3'd1) begin
            addr_q  <= {{(AW-32){1'b0}}, hi_q, ifetch_word};
            bytes_q <= 3'd4;
            state   <= S_MEM;
          end else begin
            done        <= 1'b1;
            operand     <= {{HW-16{1'b0}}, hi_q, ifetch_word};
            extra_bytes <= 3'd4;
            unsupported <= 1'b0;
            state       <= S_IDLE;
          end
        end
        S_MEM: if (mem_ready) begin
          done        <= 1'b1;
          operand     <= mem_rdata;
          extra_bytes <= bytes_q;
          unsupported <= 1'b0;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_long_fetch_chk.sv
module ea_long_fetch_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          done,
  input logic [DW-1:0] operand,
  input logic [2:0]    extra_bytes,
  input logic          unsupported
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(operand) && $stable(extra_bytes) && $stable(unsupported)) |-> done); // R10
  AST_UNSUP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unsupported) |-> (extra_bytes == 3'd0 && operand == '0)); // R8
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R9
  AST_BYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (extra_bytes == 3'd0 || extra_bytes == 3'd2 || extra_bytes == 3'd4)); // R4
endmodule

bind ea_long_fetch ea_long_fetch_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ready(mem_ready), .done(done), .operand(operand),
  .extra_bytes(extra_bytes), .unsupported(unsupported)
);

// File: tb/tb_ea_long_fetch.sv
module tb_ea_long_fetch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] ea_in = '0;
  logic [2:0] reg_idx, ifetch_off, extra_bytes;
  logic [31:0] dreg_rdata, areg_rdata, mem_addr, operand;
  logic [31:0] mem_rdata = '0;
  logic [15:0] ifetch_word;
  logic mem_req, done, unsupported;
  logic mem_ready = 1'b0;

  int errors = 0, checks = 0, wait_n = 0, wcnt = 0;
  bit finished = 0;
  logic [15:0] w4 = '0, w6 = '0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] dref(input logic [2:0] i);
    return 32'hD000_0000 | (32'(i) * 32'h111);
  endfunction
  function automatic logic [31:0] aref(input logic [2:0] i);
    return 32'h0000_8000 + 32'(i) * 32'h100;
  endfunction
  function automatic logic [31:0] memf(input logic [31:0] a);
    return ~a ^ 32'h5A5A_0F0F;
  endfunction

  assign dreg_rdata  = dref(reg_idx);
  assign areg_rdata  = aref(reg_idx);
  assign ifetch_word = (ifetch_off == 3'd4) ? w4 : (ifetch_off == 3'd6) ? w6 : 16'hDEAD;

  always @(negedge clk) begin
    mem_rdata <= memf(mem_addr);
    if (mem_req) begin
      mem_ready <= (wcnt == wait_n);
      wcnt <= (wcnt == wait_n) ? 0 : wcnt + 1;
    end else begin
      mem_ready <= 1'b0;
      wcnt <= 0;
    end
  end

  ea_long_fetch dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ea_field(ea_in), .reg_idx(reg_idx),
    .dreg_rdata(dreg_rdata), .areg_rdata(areg_rdata), .ifetch_off(ifetch_off),
    .ifetch_word(ifetch_word), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done), .operand(operand),
    .extra_bytes(extra_bytes), .unsupported(unsupported)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [5:0] ea, input logic [15:0] h4, input logic [15:0] h6,
                     input int waits, input bit poke, input string tag);
    logic [2:0] m = ea[5:3], r = ea[2:0];
    logic [31:0] addr = '0, val = '0;
    logic [2:0] bytes = '0;
    bit uns = 0, is_mem = 0;
    int lat = 1;
    case (m)
      3'd0: val = dref(r);
      3'd1: val = aref(r);
      3'd2: begin is_mem = 1; addr = aref(r); end
      3'd5: begin is_mem = 1; addr = aref(r) + {{16{h4[15]}}, h4}; bytes = 2; end
      3'd7: begin
        if (r == 3'd0) begin is_mem = 1; addr = {{16{h4[15]}}, h4}; bytes = 2; end
        else if (r == 3'd1) begin is_mem = 1; addr = {h4, h6}; bytes = 4; lat = 2; end
        else if (r == 3'd4) begin val = {h4, h6}; bytes = 4; lat = 2; end
        else uns = 1;
      end
      default: uns = 1;
    endcase
    if (is_mem) begin val = memf(addr); lat = lat + 1 + waits; end
    w4 = h4; w6 = h6; wait_n = waits;
    @(negedge clk); start = 1'b1; ea_in = ea;
    for (int j = 0; j <= lat; j++) begin
      @(negedge clk);
      if (j == 0) begin start = 1'b0; ea_in = 6'o77; end
      if (poke && j == 1) begin start = 1'b1; ea_in = 6'o00; end
      if (poke && j == 2) start = 1'b0;
      if (j < lat) begin
        chk(!done, {tag, " R10 early done"}, 32'(done), 0);
        if (is_mem && j >= lat - 1 - waits)
          chk(mem_req && mem_addr == addr, {tag, " R9 request/address"}, mem_addr, addr);
        else
          chk(!mem_req, {tag, " R8 no request"}, 32'(mem_req), 0);
      end else begin
        chk(done, {tag, " R10 done"}, 32'(done), 1);
        chk(operand == val, {tag, " operand"}, operand, val);
        chk(extra_bytes == bytes, {tag, " extra bytes"}, 32'(extra_bytes), 32'(bytes));
        chk(unsupported == uns, {tag, " R8 unsupported"}, 32'(unsupported), 32'(uns));
      end
    end
    for (int k = 0; k < (poke ? 4 : 1); k++) begin
      @(negedge clk);
      chk(!done && operand == val, {tag, " R10 hold/no extra done"}, operand, val);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && operand == 0 && extra_bytes == 0 && !unsupported,
        "R10 reset state", operand, 0);
    rst_n = 1'b1;
    run(6'o03, 16'h0, 16'h0, 0, 0, "R1 mode0 d3");
    run(6'o07, 16'h0, 16'h0, 0, 0, "R1 mode0 d7");
    run(6'o15, 16'h0, 16'h0, 0, 0, "R2 mode1 a5");
    for (int w = 0; w < 4; w++) run(6'o22, 16'h0, 16'h0, w, 0, "R3 mode2 a2");
    run(6'o51, 16'h0124, 16'h0, 1, 0, "R4 mode5 pos");
    run(6'o56, 16'hFF00, 16'h0, 0, 0, "R4 mode5 neg");
    run(6'o70, 16'h7FFE, 16'h0, 0, 0, "R5 abs short pos");
    run(6'o70, 16'h8004, 16'h0, 2, 0, "R5 abs short neg");
    run(6'o71, 16'h1234, 16'hABCC, 0, 0, "R6 abs long");
    run(6'o71, 16'hFFFF, 16'h0010, 3, 0, "R6 abs long wait");
    run(6'o74, 16'hCAFE, 16'hBEEF, 0, 0, "R7 immediate");
    run(6'o74, 16'h0000, 16'h0000, 0, 0, "R7 immediate zero");
    run(6'o30, 16'h0, 16'h0, 0, 0, "R8 mode3");
    run(6'o41, 16'h0, 16'h0, 0, 0, "R8 mode4");
    run(6'o62, 16'h0, 16'h0, 0, 0, "R8 mode6");
    run(6'o72, 16'h0, 16'h0, 0, 0, "R8 mode7 r2");
    run(6'o77, 16'h0, 16'h0, 0, 0, "R8 mode7 r7");
    run(6'o24, 16'h0, 16'h0, 4, 1, "R10 start while busy");
    run(6'o00, 16'h0, 16'h0, 0, 0, "R1 mode0 d0 after busy");
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule